// File: doc/BRIEF.md
# Base Address Register Bank with Size Probing

This block holds the 64-byte configuration header of one single-function device. A configuration decoder in front of it delivers accesses as a byte offset, a byte count and data. Six of the header dwords are base address registers. Each of them has a fixed window size and a fixed I/O-or-memory type, both set by parameters. The other dwords are plain storage whose reset contents come from a parameter.

Enumeration software finds a window's size by writing all-ones to a base register and reading it back. The bank answers by storing the complement of (size - 1), so the read returns the size mask. The low type bits of every base register cannot be overwritten. Any write that targets a dword whose current content is zero is thrown away. This keeps unimplemented base registers and the expansion-ROM register reading zero. The interrupt pin byte is fixed at 1, which names the first interrupt line.

Reads are registered, with one cycle of latency. Reset is asynchronous and active-low. Its release is synchronised to the clock by two flops inside the block.

Top module: `cfg_bar_bank`

## Requirements
- R1: After reset, each non-base dword holds its parameter value. Each base register holds its base address with the bits below its size cleared, OR'd with its type bits (bit 0 = 1 for I/O, 0 for memory). A base register whose size exponent is 0 is unused and resets to zero.
- R2: A read accepted at a clock edge gives `cfg_rvalid`=1 and `cfg_rdata` at the next edge. `cfg_rvalid` is 0 after an edge without a read. The data is the addressed dword shifted down by 8*offset[1:0], with bytes beyond the access size (and beyond the dword) zero. A read and a write in the same cycle return the value from before the write.
- R3: A 4-byte aligned write of 0xFFFFFFFF to a base register stores ~(2^n - 1), where n is that register's size exponent, merged with its type bits per R4. Base registers are at byte offsets 0x10 + 4*i for i = 0..5.
- R4: On any base register write, the stored value is (new & mask) | (old & ~mask). The mask clears bits 1:0 for I/O registers and bits 3:0 for memory registers, so the type bits never change.
- R5: Partial writes to a base register update only the addressed byte lanes. Those lanes follow the merge of R4, and an all-ones partial write is not treated as a probe.
- R6: A write to any dword whose current content is zero has no effect. This includes unused base registers, the ROM register at 0x30, and a base register that has been written to zero.
- R7: Writes to non-base dwords are stored unmodified, in the enabled lanes only. Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The lanes run upward from offset[1:0] and are clipped at the end of the dword. Without a write, no dword changes.
- R8: The interrupt pin byte at offset 0x3D always reads 1, and writes to it are ignored. The other bytes of that dword are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_rd_en | input | 1 | Read strobe |
| cfg_off | input | 6 | Byte offset in the header |
| cfg_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| cfg_wdata | input | 32 | Write data, least significant byte first |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read |

## Verification
The hardest state to reach from the ports is a base register that has been emptied. A full-word write of a value whose address bits are zero clears a memory register whose type bits are zero. After that, every further write, including a probe, must be dropped. The stimulus reaches this state on purpose and then probes that register. A second hard case is an all-ones write that is not a full aligned word, which must merge and not probe. Randomised writes with a weighted share of all-ones data, at every offset and size, cover it. They are checked against a byte-level reference model.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
  localparam int HDR_DWORDS   = 16;
  localparam int OFF_W        = $clog2(HDR_DWORDS * 4);
  localparam int DW_IDX_W     = OFF_W - 2;
  localparam int NUM_BARS     = 6;
  localparam int FIRST_BAR_DW = 4;
  localparam int LAST_BAR_DW  = FIRST_BAR_DW + NUM_BARS - 1;
  localparam int PIN_DW       = 15;
  localparam logic [3:0]  PIN_LANES  = 4'b0010;
  localparam logic [31:0] PIN_VALUE  = 32'h0000_0100;
  localparam logic [31:0] IO_KEEP    = 32'hFFFF_FFFC;
  localparam logic [31:0] MEM_KEEP   = 32'hFFFF_FFF0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_ALT  = 2'd3
  } acc_size_e;

  function automatic logic [31:0] lanes_to_bits(input logic [3:0] lanes);
    logic [31:0] b;
    for (int i = 0; i < 4; i++) b[8*i +: 8] = {8{lanes[i]}};
    return b;
  endfunction

  function automatic logic [31:0] rd_format(input logic [31:0] w,
                                            input logic [1:0]  lo,
                                            input logic [1:0]  sz);
    logic [31:0] s;
    s = w >> {lo, 3'b000};
    case (acc_size_e'(sz))
      SZ_BYTE: return {24'h0, s[7:0]};
      SZ_HALF: return {16'h0, s[15:0]};
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfgbar_pkg::*;
(
  input  logic [1:0]  off_lo,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [3:0]  lane_en,
  output logic [31:0] wdata_al
);
  logic [3:0] span;
  logic [7:0] shifted;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: span = 4'b0001;
      SZ_HALF: span = 4'b0011;
      default: span = 4'b1111;
    endcase
    shifted  = {4'b0000, span} << off_lo;
    lane_en  = shifted[3:0];
    wdata_al = wdata << {off_lo, 3'b000};
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfgbar_pkg::*;
#(
  parameter int          SIZE_LOG2 = 12,
  parameter bit          IS_IO     = 1'b0,
  parameter logic [31:0] BASE      = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  lane_en,
  input  logic [31:0] wdata_al,
  output logic [31:0] q
);
  localparam logic [31:0] KEEP      = IS_IO ? IO_KEEP : MEM_KEEP;
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : 32'h0;
  localparam logic [31:0] SIZE_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
  localparam logic [31:0] RST_VAL   = (SIZE_LOG2 == 0) ? 32'h0
                                      : ((BASE & SIZE_MASK & KEEP) | TYPE_BITS);

  logic [31:0] bar_q, bar_d, src, merged;
  logic        probe;

  always_comb begin
    probe  = (lane_en == 4'hF) && (wdata_al == 32'hFFFF_FFFF);
    src    = probe ? SIZE_MASK : wdata_al;
    merged = (src & KEEP) | (bar_q & ~KEEP);
    bar_d  = bar_q;
    for (int i = 0; i < 4; i++) begin
      if (wr_hit && lane_en[i]) bar_d[8*i +: 8] = merged[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bar_q <= RST_VAL;
    else        bar_q <= bar_d;
  end

  assign q = bar_q;
endmodule

// File: rtl/cfg_hdr_word.sv
module cfg_hdr_word
  import cfgbar_pkg::*;
#(
  parameter logic [31:0] INIT     = 32'h0,
  parameter logic [3:0]  RO_LANES = 4'b0000,
  parameter logic [31:0] RO_VAL   = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  lane_en,
  input  logic [31:0] wdata_al,
  output logic [31:0] q
);
  localparam logic [31:0] RO_BITS = lanes_to_bits(RO_LANES);
  localparam logic [31:0] RST_VAL = (INIT & ~RO_BITS) | (RO_VAL & RO_BITS);

  logic [31:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    for (int i = 0; i < 4; i++) begin
      if (RO_LANES[i])                  word_d[8*i +: 8] = RO_VAL[8*i +: 8];
      else if (wr_hit && lane_en[i])    word_d[8*i +: 8] = wdata_al[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RST_VAL;
    else        word_q <= word_d;
  end

  assign q = word_q;
endmodule

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
  import cfgbar_pkg::*;
#(
  parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b01_0010,
  parameter int          BAR_SZ_LOG2 [NUM_BARS] = '{12, 8, 0, 16, 4, 0},
  parameter logic [31:0] BAR_BASE    [NUM_BARS] = '{32'hC000_0000, 32'h0000_C100,
                                                    32'h0, 32'hD001_0000,
                                                    32'h0000_1040, 32'h0},
  parameter logic [31:0] HDR_INIT  [HDR_DWORDS] = '{32'h7E11_C0DE, 32'h0010_0006,
                                                    32'h0200_0001, 32'h0000_0010,
                                                    32'h0, 32'h0, 32'h0, 32'h0,
                                                    32'h0, 32'h0, 32'h0,
                                                    32'h00A1_00B2, 32'h0,
                                                    32'h0000_0040, 32'h0,
                                                    32'h0000_000B}
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cfg_wr_en,
  input  logic             cfg_rd_en,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic [1:0]       cfg_size,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_rvalid
);
  logic                rst_sync_n;
  logic [DW_IDX_W-1:0] dw_sel;
  logic [3:0]          lane_en;
  logic [31:0]         wdata_al;
  logic [31:0]         word_q [HDR_DWORDS];
  logic                target_nz, wr_ok;
  logic [31:0]         rdata_q, rdata_d;
  logic                rvalid_q, rvalid_d;

  cfg_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cfg_lane_unit u_lane (
    .off_lo   (cfg_off[1:0]),
    .size     (cfg_size),
    .wdata    (cfg_wdata),
    .lane_en  (lane_en),
    .wdata_al (wdata_al)
  );

  assign dw_sel    = cfg_off[OFF_W-1:2];
  assign target_nz = (word_q[dw_sel] != 32'h0);
  assign wr_ok     = cfg_wr_en && target_nz;

  for (genvar g = 0; g < HDR_DWORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_ok && (dw_sel == DW_IDX_W'(g));
    if (g >= FIRST_BAR_DW && g <= LAST_BAR_DW) begin : g_bar
      cfg_bar_slot #(
        .SIZE_LOG2 (BAR_SZ_LOG2[g-FIRST_BAR_DW]),
        .IS_IO     (BAR_IS_IO[g-FIRST_BAR_DW]),
        .BASE      (BAR_BASE[g-FIRST_BAR_DW])
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .wr_hit   (hit),
        .lane_en  (lane_en),
        .wdata_al (wdata_al),
        .q        (word_q[g])
      );
    end else begin : g_plain
      cfg_hdr_word #(
        .INIT     (HDR_INIT[g]),
        .RO_LANES ((g == PIN_DW) ? PIN_LANES : 4'b0000),
        .RO_VAL   ((g == PIN_DW) ? PIN_VALUE : 32'h0)
      ) u_word (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .wr_hit   (hit),
        .lane_en  (lane_en),
        .wdata_al (wdata_al),
        .q        (word_q[g])
      );
    end
  end

  always_comb begin
    rvalid_d = cfg_rd_en;
    rdata_d  = rdata_q;
    if (cfg_rd_en) rdata_d = rd_format(word_q[dw_sel], cfg_off[1:0], cfg_size);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 32'h0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign cfg_rdata  = rdata_q;
  assign cfg_rvalid = rvalid_q;
endmodule

// File: rtl/cfg_bar_bank_chk.sv
module cfg_bar_bank_chk
  import cfgbar_pkg::*;
#(
  parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b01_0010
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        rvalid,
  input logic [31:0] words [HDR_DWORDS]
);
  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r2_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  a_r8_pin_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    words[PIN_DW][15:8] == 8'h01);

  for (genvar g = 0; g < HDR_DWORDS; g++) begin : g_w
    a_r6_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (words[g] == 32'h0) |=> (words[g] == 32'h0));
    a_r7_quiet_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(words[g]));
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_b
    if (BAR_IS_IO[b]) begin : g_io
      a_r4_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(words[FIRST_BAR_DW+b][1:0]));
    end else begin : g_mem
      a_r4_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(words[FIRST_BAR_DW+b][3:0]));
    end
  end
endmodule

bind cfg_bar_bank cfg_bar_bank_chk #(.BAR_IS_IO(BAR_IS_IO)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (cfg_wr_en),
  .rd_en  (cfg_rd_en),
  .rvalid (cfg_rvalid),
  .words  (word_q)
);

// File: tb/cfg_bar_bank_bench.sv
`timescale 1ns/1ps
module cfg_bar_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [5:0]  cfg_off = '0;
  logic [1:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [16];
  int          szl [6] = '{12, 8, 0, 16, 4, 0};
  bit          isio [6] = '{0, 1, 0, 0, 1, 0};

  always #4 clk = ~clk;

  cfg_bar_bank u_cfg_bar_bank (.*);

  function automatic logic [31:0] size_mask(int n);
    return ~((32'd1 << n) - 32'd1);
  endfunction

  task automatic model_reset();
    logic [31:0] base [6] = '{32'hC000_0000, 32'h0000_C100, 32'h0, 32'hD001_0000,
                              32'h0000_1040, 32'h0};
    mdl = '{32'h7E11_C0DE, 32'h0010_0006, 32'h0200_0001, 32'h0000_0010,
            0, 0, 0, 0, 0, 0, 0, 32'h00A1_00B2, 0, 32'h0000_0040, 0, 32'h0000_010B};
    for (int b = 0; b < 6; b++) begin
      logic [31:0] keep = isio[b] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
      mdl[4+b] = (szl[b] == 0) ? 32'h0
               : ((base[b] & size_mask(szl[b]) & keep) | (isio[b] ? 32'h1 : 32'h0));
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] off, logic [1:0] sz);
    logic [31:0] s = mdl[off[5:2]] >> (8 * off[1:0]);
    if (sz == 0) return {24'h0, s[7:0]};
    if (sz == 1) return {16'h0, s[15:0]};
    return s;
  endfunction

  task automatic model_write(logic [5:0] off, logic [1:0] sz, logic [31:0] d);
    int dw = off[5:2];
    logic [31:0] al = d << (8 * off[1:0]);
    logic [31:0] v = al;
    logic [3:0] ln = '0;
    if (mdl[dw] == 0) return;
    for (int i = 0; i < nbytes(sz); i++) if (off[1:0] + i < 4) ln[off[1:0]+i] = 1'b1;
    if (dw >= 4 && dw <= 9) begin
      int b = dw - 4;
      logic [31:0] keep = isio[b] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
      if (ln == 4'hF && al == 32'hFFFF_FFFF) v = size_mask(szl[b]);
      v = (v & keep) | (mdl[dw] & ~keep);
    end
    for (int i = 0; i < 4; i++)
      if (ln[i] && !(dw == 15 && i == 1)) mdl[dw][8*i +: 8] = v[8*i +: 8];
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [5:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
    model_write(off, sz, d);
  endtask

  task automatic do_read(string req, logic [5:0] off, logic [1:0] sz);
    logic [31:0] e = exp_read(off, sz);
    @(negedge clk);
    cfg_rd_en = 1; cfg_off = off; cfg_size = sz;
    @(negedge clk);
    cfg_rd_en = 0;
    check({req, " rvalid"}, {31'h0, cfg_rvalid}, 32'h1);
    check(req, cfg_rdata, e);
  endtask

  task automatic do_rw(logic [5:0] off, logic [1:0] sz, logic [31:0] d);
    logic [31:0] e = exp_read(off, sz);
    @(negedge clk);
    cfg_rd_en = 1; cfg_wr_en = 1; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_rd_en = 0; cfg_wr_en = 0;
    check("R2 read-before-write", cfg_rdata, e);
    model_write(off, sz, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check("R2 rvalid idle after reset", {31'h0, cfg_rvalid}, 32'h0);
    for (int i = 0; i < 16; i++) do_read("R1 reset value", 6'(4*i), 2'd2);
    @(negedge clk);
    check("R2 rvalid drops", {31'h0, cfg_rvalid}, 32'h0);

    // R3 probes then address write-back
    do_write(6'h10, 2, 32'hFFFF_FFFF); do_read("R3 probe mem 4K", 6'h10, 2);
    check("R3 probe mem 4K value", mdl[4], 32'hFFFF_F000);
    do_write(6'h14, 2, 32'hFFFF_FFFF); do_read("R3 probe io 256", 6'h14, 2);
    check("R3 probe io value", mdl[5], 32'hFFFF_FF01);
    do_write(6'h1C, 2, 32'hFFFF_FFFF); do_read("R3 probe mem 64K", 6'h1C, 2);
    do_write(6'h20, 2, 32'hFFFF_FFFF); do_read("R3 probe io 16", 6'h20, 2);
    do_write(6'h10, 2, 32'hC000_200F); do_read("R4 mem type kept", 6'h10, 2);
    do_write(6'h14, 2, 32'h0000_D0FE); do_read("R4 io type kept", 6'h14, 2);
    // R5 partial BAR writes
    do_write(6'h14, 0, 32'h0000_00FF); do_read("R5 byte lane io", 6'h14, 2);
    do_write(6'h12, 1, 32'h0000_FFFF); do_read("R5 half all-ones no probe", 6'h10, 2);
    // R6 zero drop
    do_write(6'h18, 2, 32'hFFFF_FFFF); do_read("R6 unused bar", 6'h18, 2);
    do_write(6'h30, 2, 32'h1234_5678); do_read("R6 rom dropped", 6'h30, 2);
    do_write(6'h1C, 2, 32'h0000_0000); do_read("R6 bar cleared", 6'h1C, 2);
    do_write(6'h1C, 2, 32'hFFFF_FFFF); do_read("R6 cleared bar locked", 6'h1C, 2);
    check("R6 locked value", mdl[7], 32'h0);
    // R7 plain storage
    do_write(6'h06, 1, 32'h0000_ABCD); do_read("R7 half write", 6'h04, 2);
    do_write(6'h0C, 2, 32'hFFFF_FFFF); do_read("R7 all-ones stored", 6'h0C, 2);
    do_write(6'h2F, 1, 32'h0000_9988); do_read("R7 lanes clipped", 6'h2C, 2);
    do_read("R2 byte read", 6'h01, 0);
    do_read("R2 half read clipped", 6'h03, 1);
    // R8 interrupt pin
    do_write(6'h3D, 0, 32'h0000_00EE); do_read("R8 pin read", 6'h3D, 0);
    do_write(6'h3C, 2, 32'h1122_3344); do_read("R8 pin and line", 6'h3C, 2);
    do_rw(6'h08, 2, 32'h5555_AAAA); do_read("R7 after rw", 6'h08, 2);

    for (int n = 0; n < 600; n++) begin
      logic [5:0] off = 6'($urandom_range(0, 63));
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom();
      case ($urandom_range(0, 2))
        0: do_write(off, sz, d);
        1: do_read("R2 R7 random read", off, sz);
        default: begin do_write(off, sz, d); do_read("R3 R5 random", {off[5:2], 2'b00}, 2); end
      endcase
    end
    finish_run();
  end
endmodule